// File: doc/BRIEF.md
# Burst-Read Register Address Sequencer

This block keeps the register pointer that a serial read port uses while it streams sensor output bytes to a host. A transaction loads a start address; every byte the port hands out then moves the pointer on by one auto-increment step. Two sensor output blocks sit at separate addresses: one for acceleration and one for magnetic field. Each block holds six bytes: X high, X low, Y high, Y low, Z high, Z low. A pointer outside both blocks simply counts upward and wraps at the top of the address space.

A fast-read setting makes the pointer jump over every low byte, so a burst returns only high bytes. When the part runs both sensors and the chaining option is on, the end of the acceleration block leads into the start of the magnetic block, and the end of the magnetic block leads back. With fast-read on, a 6-byte burst from the acceleration X high byte therefore returns the high bytes of all six axes. The fast-read setting is held here. A write to it is accepted only while the sample-buffer mode field is zero.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the pointer `regAddr` is 0 and `fastRead` is 0.
- R2: When `startValid` is high at a clock edge, `regAddr` equals `startAddr` after that edge. This holds even when `readStrobe` is high in the same cycle.
- R3: With `fastRead` at 0, a read strobe on a byte at offset 0 to 4 of either output block moves the pointer to the next address.
- R4: With `fastRead` at 1, a read strobe inside an output block moves the pointer to the next high byte (the next even offset), skipping low bytes. The high bytes are at offsets 0, 2 and 4.
- R5: When chaining is off, the acceleration block wraps to its own offset 0 after its last byte (offset 5 normally, offset 4 with fast-read).
- R6: When `hybridEn` and `hybChainEn` are both 1, the step after the last acceleration byte goes to the magnetic block base. The step after the last magnetic byte goes to the acceleration block base.
- R7: When chaining is off, the magnetic block wraps to its own offset 0 after its last byte.
- R8: `cfgWrEn` loads `cfgFastRead` into `fastRead` only when `fifoMode` is 0. With any other `fifoMode` value, `fastRead` keeps its value.
- R9: A read strobe at an address outside both blocks increments the pointer by one, modulo 2^ADDR_W.
- R10: With neither `startValid` nor `readStrobe` high, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Load start address for a new transaction |
| startAddr | input | ADDR_W | Transaction start address |
| readStrobe | input | 1 | One byte read at the current address |
| hybridEn | input | 1 | Both sensors active |
| hybChainEn | input | 1 | Chain the acceleration and magnetic blocks in hybrid operation |
| fifoMode | input | FMODE_W | Sample-buffer mode field; 0 means the buffer is off |
| cfgWrEn | input | 1 | Write strobe for the fast-read setting |
| cfgFastRead | input | 1 | Value to write to the fast-read setting |
| regAddr | output | ADDR_W | Current register pointer |
| fastRead | output | 1 | Current fast-read setting |

## Verification
The bench uses the default parameters: an 8-bit address, the acceleration block at 0x01, the magnetic block at 0x33, and a 2-bit mode field. The blocks are small enough that every offset, every wrap and every chain hop is reached within a few strobes. Because the address is only 8 bits wide, a pointer loaded at 0xFF reaches the rollover to 0x00 after a single strobe. A non-zero mode value such as 2 shows that a rejected write leaves the setting unchanged.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes passed from the control half to the pointer datapath
  typedef struct packed {
    logic load;     // take the start address
    logic step;     // advance by one auto-increment step
    logic skipLsb;  // fast-read stepping
    logic chain;    // hop between the two output blocks
  } seqCmd_t;
endpackage

// File: rtl/burst_blk_decode.sv
module burst_blk_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int NBYTES = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              skipLsb,
  output logic              hit,
  output logic              wrap,
  output logic [ADDR_W-1:0] nextAddr
);
  localparam logic [ADDR_W-1:0] NB = ADDR_W'(NBYTES);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] nextOff;

  always_comb begin
    off      = addr - BASE;
    hit      = (off < NB);
    nextOff  = skipLsb ? ((off | ADDR_W'(1)) + ADDR_W'(1)) : (off + ADDR_W'(1));
    wrap     = (nextOff >= NB);
    nextAddr = BASE + nextOff;
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int FMODE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               readStrobe,
  input  logic               hybridEn,
  input  logic               hybChainEn,
  input  logic [FMODE_W-1:0] fifoMode,
  input  logic               cfgWrEn,
  input  logic               cfgFastRead,
  output seqCmd_t            cmd,
  output logic               fastRead
);
  logic fastReadQ;
  logic wrOk;

  assign wrOk = cfgWrEn && (fifoMode == '0);

  always_ff @(posedge clk) begin
    if (!rstN)     fastReadQ <= 1'b0;
    else if (wrOk) fastReadQ <= cfgFastRead;
  end

  always_comb begin
    cmd.load    = startValid;
    cmd.step    = readStrobe && !startValid;
    cmd.skipLsb = fastReadQ;
    cmd.chain   = hybridEn && hybChainEn;
  end

  assign fastRead = fastReadQ;

  // R8: a write while the buffer mode is non-zero is refused
  p_fr_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && fifoMode != '0) |=> $stable(fastRead));
  // R8: a write while the buffer mode is zero takes the new value
  p_fr_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && fifoMode == '0) |=> fastRead == $past(cfgFastRead));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ACC_BASE = 8'h01,
  parameter logic [ADDR_W-1:0] MAG_BASE = 8'h33,
  parameter int BLK_BYTES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] regAddr
);
  localparam int NBLK = 2;
  localparam logic [ADDR_W-1:0] BASES [NBLK] = '{ACC_BASE, MAG_BASE};

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptrNext;
  logic [NBLK-1:0]   blkHit;
  logic [NBLK-1:0]   blkWrap;
  logic [ADDR_W-1:0] blkNext [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    burst_blk_decode #(
      .ADDR_W (ADDR_W),
      .BASE   (BASES[g]),
      .NBYTES (BLK_BYTES)
    ) u_dec (
      .addr     (ptr),
      .skipLsb  (cmd.skipLsb),
      .hit      (blkHit[g]),
      .wrap     (blkWrap[g]),
      .nextAddr (blkNext[g])
    );
  end

  // Step rule: stay in block, wrap to own base, or hop to the other block
  always_comb begin
    if (blkHit[0])
      ptrNext = !blkWrap[0] ? blkNext[0] : (cmd.chain ? MAG_BASE : ACC_BASE);
    else if (blkHit[1])
      ptrNext = !blkWrap[1] ? blkNext[1] : (cmd.chain ? ACC_BASE : MAG_BASE);
    else
      ptrNext = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ptr <= '0;
    else if (cmd.load) ptr <= startAddr;
    else if (cmd.step) ptr <= ptrNext;
  end

  assign regAddr = ptr;

  // R2: a new start address wins
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> regAddr == $past(startAddr));
  // R10: no strobe, no movement
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(regAddr));
  // R4: fast-read stepping inside the acceleration block lands on a high byte
  p_msb_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && cmd.skipLsb && blkHit[0] && !blkWrap[0])
      |=> ((regAddr - ACC_BASE) & ADDR_W'(1)) == '0);
  // R6: chained hop from the end of the acceleration block
  p_chain_acc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && cmd.chain && blkHit[0] && blkWrap[0]) |=> regAddr == MAG_BASE);
  // R6: chained hop from the end of the magnetic block
  p_chain_mag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && cmd.chain && blkHit[1] && blkWrap[1]) |=> regAddr == ACC_BASE);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ACC_BASE = 8'h01,
  parameter logic [ADDR_W-1:0] MAG_BASE = 8'h33,
  parameter int BLK_BYTES = 6,
  parameter int FMODE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic               readStrobe,
  input  logic               hybridEn,
  input  logic               hybChainEn,
  input  logic [FMODE_W-1:0] fifoMode,
  input  logic               cfgWrEn,
  input  logic               cfgFastRead,
  output logic [ADDR_W-1:0]  regAddr,
  output logic               fastRead
);
  seqCmd_t cmd;

  burst_seq_ctrl #(.FMODE_W(FMODE_W)) u_ctrl (
    .clk, .rstN, .startValid, .readStrobe, .hybridEn, .hybChainEn,
    .fifoMode, .cfgWrEn, .cfgFastRead, .cmd, .fastRead
  );

  burst_seq_dp #(
    .ADDR_W(ADDR_W), .ACC_BASE(ACC_BASE), .MAG_BASE(MAG_BASE), .BLK_BYTES(BLK_BYTES)
  ) u_dp (
    .clk, .rstN, .cmd, .startAddr, .regAddr
  );

  // R1: reset value of the pointer
  p_reset_r1: assert property (@(posedge clk) !rstN |=> (regAddr == '0 && !fastRead));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] startAddr = '0;
  logic       readStrobe = 1'b0;
  logic       hybridEn = 1'b0;
  logic       hybChainEn = 1'b0;
  logic [1:0] fifoMode = '0;
  logic       cfgWrEn = 1'b0;
  logic       cfgFastRead = 1'b0;
  logic [7:0] regAddr;
  logic       fastRead;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq u_dut (
    .clk, .rstN, .startValid, .startAddr, .readStrobe, .hybridEn, .hybChainEn,
    .fifoMode, .cfgWrEn, .cfgFastRead, .regAddr, .fastRead
  );

  // Row: req(4) ld(1) adr(8) rd(1) wr(1) wv(1) fifo(2) chain(1) expA(8) expF(1)
  localparam int NV = 33;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2, 1'b1,8'h01,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'h01,1'b0}, // R2
    {4'd3, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h02,1'b0}, // R3
    {4'd3, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h03,1'b0}, // R3
    {4'd3, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h04,1'b0}, // R3
    {4'd3, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h05,1'b0}, // R3
    {4'd3, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h06,1'b0}, // R3
    {4'd5, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h01,1'b0}, // R5
    {4'd2, 1'b1,8'h06,1'b0, 1'b0,1'b0,2'd0, 1'b1, 8'h06,1'b0}, // R2
    {4'd6, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h33,1'b0}, // R6
    {4'd2, 1'b1,8'h38,1'b0, 1'b0,1'b0,2'd0, 1'b1, 8'h38,1'b0}, // R2
    {4'd6, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h01,1'b0}, // R6
    {4'd2, 1'b1,8'h38,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'h38,1'b0}, // R2
    {4'd7, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h33,1'b0}, // R7
    {4'd8, 1'b0,8'h00,1'b0, 1'b1,1'b1,2'd0, 1'b0, 8'h33,1'b1}, // R8, R10
    {4'd2, 1'b1,8'h01,1'b0, 1'b0,1'b0,2'd0, 1'b1, 8'h01,1'b1}, // R2
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h03,1'b1}, // R4
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h05,1'b1}, // R4
    {4'd6, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h33,1'b1}, // R6
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h35,1'b1}, // R4
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h37,1'b1}, // R4
    {4'd6, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b1, 8'h01,1'b1}, // R6
    {4'd2, 1'b1,8'h02,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'h02,1'b1}, // R2
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h03,1'b1}, // R4 from low byte
    {4'd8, 1'b0,8'h00,1'b0, 1'b1,1'b0,2'd2, 1'b0, 8'h03,1'b1}, // R8 refused
    {4'd4, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd2, 1'b0, 8'h05,1'b1}, // R4
    {4'd5, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h01,1'b1}, // R5 fast wrap
    {4'd8, 1'b0,8'h00,1'b0, 1'b1,1'b0,2'd0, 1'b0, 8'h01,1'b0}, // R8 accepted
    {4'd2, 1'b1,8'h20,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'h20,1'b0}, // R2
    {4'd9, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h21,1'b0}, // R9
    {4'd2, 1'b1,8'hFF,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'hFF,1'b0}, // R2
    {4'd9, 1'b0,8'h00,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h00,1'b0}, // R9 rollover
    {4'd2, 1'b1,8'h10,1'b1, 1'b0,1'b0,2'd0, 1'b0, 8'h10,1'b0}, // R2 priority
    {4'd10,1'b0,8'h00,1'b0, 1'b0,1'b0,2'd0, 1'b0, 8'h10,1'b0}  // R10
  };

  task automatic check(input int req, input logic [7:0] gotA, input logic [7:0] expA,
                       input logic gotF, input logic expF);
    nChk++;
    if (gotA !== expA || gotF !== expF) begin
      nBad++;
      $display("FAIL R%0d: regAddr=%h fastRead=%b expected regAddr=%h fastRead=%b",
               req, gotA, gotF, expA, expF);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check(1, regAddr, 8'h00, fastRead, 1'b0); // R1 reset state
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      startValid  = VEC[i][23];
      startAddr   = VEC[i][22:15];
      readStrobe  = VEC[i][14];
      cfgWrEn     = VEC[i][13];
      cfgFastRead = VEC[i][12];
      fifoMode    = VEC[i][11:10];
      hybridEn    = VEC[i][9];
      hybChainEn  = VEC[i][9];
      @(posedge clk); #1;
      check(int'(VEC[i][27:24]), regAddr, VEC[i][8:1], fastRead, VEC[i][0]);
    end
    // R6 needs both enables: hybrid alone does not chain (R5)
    startValid = 1'b1; startAddr = 8'h06; readStrobe = 1'b0; cfgWrEn = 1'b0;
    hybridEn = 1'b1; hybChainEn = 1'b0;
    @(posedge clk); #1;
    startValid = 1'b0; readStrobe = 1'b1;
    @(posedge clk); #1;
    check(5, regAddr, 8'h01, fastRead, 1'b0); // R5
    // R1: reset mid-run clears pointer and fast-read
    readStrobe = 1'b0; cfgWrEn = 1'b1; cfgFastRead = 1'b1; fifoMode = 2'd0;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    check(8, regAddr, 8'h01, fastRead, 1'b1); // R8
    rstN = 1'b0;
    @(posedge clk); #1;
    check(1, regAddr, 8'h00, fastRead, 1'b0); // R1
    rstN = 1'b1;
    @(posedge clk); #1;
    check(10, regAddr, 8'h00, fastRead, 1'b0); // R10 idle after reset
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule